// File: doc/BRIEF.md
# Triggered Acquisition Sequencer

This block paces the acquisition of up to fifteen digitizer channels. All channels share one sample clock and one record depth. Software first loads a set-up word, which holds the rate divider, the depth select, the sample-clock source and the channel address. It then arms the block and starts the record with a trigger. The trigger is either a one-cycle strobe from the command decoder or a rising edge on an asynchronous external trigger pin.

While a record runs, each sample tick produces a one-cycle convert pulse on the enabled channels. The write address that belongs to that sample is presented alongside the pulse. A sample tick comes from one of three sources:
- a programmable divider on the core clock;
- the edges of an external sample clock;
- a fixed divider that gives a reference rate.

The record ends when the last address of the selected depth has been written, or earlier on an end-of-record strobe. The block then holds in a done state until it is armed again. The converters and the memory cells are not part of this block.

Top module: `acq_seq`

## Requirements
- R1: After reset the block is idle: busy_o=0, done_o=0, cnv_o=0, addr_o=0 and chan_o=0.
- R2: arm_i moves the block from idle or done to armed (busy_o=1, done_o=0) and restarts the write address at 0. A trigger of either kind while idle leaves the block idle and produces no convert pulse.
- R3: While armed, a trig_i strobe or a rising edge of ext_trig_i starts the record. ext_trig_i passes through a two-flop synchronizer first.
- R4: Channel address 0 enables all 15 convert lines. Channel address k in 1..15 enables only cnv_o bit k-1.
- R5: Depth select 0, 1, 2 and 3 give 8192, 32768, 65536 and 131072 words. Each sample raises cnv_o for one cycle, with addr_o holding that sample's address. Addresses run 0, 1, 2 and so on, and the record ends in done (busy_o=0, done_o=1) right after the sample at depth minus one.
- R6: Source select 0 gives one sample every div+1 core cycles. Source select 1 gives one sample per rising edge of the synchronized ext_clk_i. Source select 2 or 3 gives one sample every FIX_DIV core cycles (default 125, which is 2 MHz from a 250 MHz core clock).
- R7: eor_i while armed or acquiring moves the block to done at once. No convert pulse follows.
- R8: setup_i loads the set-up word only while the block is idle or done. While it is armed or acquiring, the word is ignored and the running rate, depth, source and channel are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_i | input | 1 | Load strobe for the set-up word |
| setup_div_i | input | 21 | Internal divider value; period is value+1 cycles |
| setup_depth_i | input | 2 | Record depth select |
| setup_src_i | input | 2 | Sample clock source select |
| setup_chan_i | input | 4 | Channel address |
| arm_i | input | 1 | Arm strobe |
| trig_i | input | 1 | Software trigger strobe |
| eor_i | input | 1 | Forced end-of-record strobe |
| ext_trig_i | input | 1 | Asynchronous external trigger |
| ext_clk_i | input | 1 | Asynchronous external sample clock |
| cnv_o | output | 15 | Convert pulse per channel |
| addr_o | output | 17 | Write address of the current sample |
| chan_o | output | 4 | Channel address in use |
| busy_o | output | 1 | Armed or acquiring |
| done_o | output | 1 | Record complete |

## Verification
Full records are run through four combinations of trigger, source, depth and channel:
- software trigger, divider 1, 8K depth, broadcast address;
- external trigger, external clock toggling every cycle, 8K depth, channel 5;
- divider 0, 32K depth, channel 15;
- divider 0, 64K depth, channel 1.

Between them, these runs tell apart the two trigger paths, the sample spacing of two sources, the three depth limits and the broadcast and single-channel decodes. A short run on the fixed reference source is stopped by the end-of-record strobe. It confirms the 125-cycle spacing and that no pulse follows the abort. A trigger while idle, a set-up write in the middle of a record and an abort while armed cover the cases that must have no effect or that end the sequence early.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_ACQ   = 2'd2,
    ST_DONE  = 2'd3
  } acq_state_e;

  localparam logic [1:0] SRC_DIV = 2'd0;
  localparam logic [1:0] SRC_EXT = 2'd1;

  // log2 of record depth per select code
  function automatic int unsigned depth_log2(input logic [1:0] sel);
    case (sel)
      2'd0:    return 13;
      2'd1:    return 15;
      2'd2:    return 16;
      default: return 17;
    endcase
  endfunction
endpackage

// File: rtl/acq_sync_edge.sv
module acq_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/acq_tick_gen.sv
module acq_tick_gen
  import acq_pkg::*;
#(
  parameter int unsigned DIV_W   = 21,
  parameter int unsigned FIX_DIV = 125
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [1:0]       src_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ext_rise_i,
  output logic             tick_o
);
  localparam int unsigned FIX_W = $clog2(FIX_DIV);
  localparam int unsigned CNT_W = (DIV_W > FIX_W) ? DIV_W : FIX_W;

  logic [CNT_W-1:0] cnt_q, lim;
  logic             use_ext;

  assign use_ext = (src_i == SRC_EXT);
  assign lim     = (src_i == SRC_DIV) ? CNT_W'(div_i) : CNT_W'(FIX_DIV - 1);
  assign tick_o  = run_i & (use_ext ? ext_rise_i : (cnt_q == lim));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || use_ext)   cnt_q <= '0;
    else if (cnt_q == lim)        cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  // R6
  div_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && run_i && src_i == SRC_DIV && div_i != '0) |=> !tick_o);
endmodule

// File: rtl/acq_chan_dec.sv
module acq_chan_dec #(
  parameter int unsigned NCH  = 15,
  parameter int unsigned CH_W = 4
) (
  input  logic [CH_W-1:0] chan_i,
  output logic [NCH-1:0]  mask_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign mask_o[i] = (chan_i == '0) || (chan_i == CH_W'(i + 1));
  end

  // R4
  always_comb begin
    if (chan_i != '0 && int'(chan_i) <= NCH)
      single_sel_chk: assert ($countones(mask_o) == 1);
  end
endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int unsigned NCH    = 15,
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              trig_i,
  input  logic              eor_i,
  input  logic              tick_i,
  input  logic [1:0]        depth_i,
  input  logic [NCH-1:0]    mask_i,
  output acq_state_e        state_o,
  output logic [NCH-1:0]    cnv_o,
  output logic [ADDR_W-1:0] addr_o
);
  acq_state_e        st_q;
  logic [ADDR_W-1:0] wr_q, last;

  assign last    = ADDR_W'((32'd1 << depth_log2(depth_i)) - 32'd1);
  assign state_o = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      wr_q   <= '0;
      cnv_o  <= '0;
      addr_o <= '0;
    end else begin
      cnv_o <= '0;
      case (st_q)
        ST_IDLE, ST_DONE: begin
          if (arm_i) begin
            st_q <= ST_ARMED;
            wr_q <= '0;
          end
        end
        ST_ARMED: begin
          if (eor_i)       st_q <= ST_DONE;
          else if (trig_i) st_q <= ST_ACQ;
        end
        default: begin
          if (eor_i) st_q <= ST_DONE;
          else if (tick_i) begin
            cnv_o  <= mask_i;
            addr_o <= wr_q;
            wr_q   <= wr_q + 1'b1;
            if (wr_q == last) st_q <= ST_DONE;
          end
        end
      endcase
    end
  end

  // R2
  idle_trig_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !arm_i) |=> (st_q == ST_IDLE && cnv_o == '0));
  // R5
  addr_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnv_o != '0) |-> (addr_o <= last));
  // R5
  end_of_record_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACQ && tick_i && !eor_i && wr_q == last) |=> (st_q == ST_DONE));
  // R7
  eor_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eor_i && (st_q == ST_ARMED || st_q == ST_ACQ)) |=> (st_q == ST_DONE && cnv_o == '0));
endmodule

// File: rtl/acq_seq.sv
module acq_seq
  import acq_pkg::*;
#(
  parameter int unsigned NCH         = 15,
  parameter int unsigned CH_W        = 4,
  parameter int unsigned DIV_W       = 21,
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned FIX_DIV     = 125,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              setup_i,
  input  logic [DIV_W-1:0]  setup_div_i,
  input  logic [1:0]        setup_depth_i,
  input  logic [1:0]        setup_src_i,
  input  logic [CH_W-1:0]   setup_chan_i,
  input  logic              arm_i,
  input  logic              trig_i,
  input  logic              eor_i,
  input  logic              ext_trig_i,
  input  logic              ext_clk_i,
  output logic [NCH-1:0]    cnv_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              busy_o,
  output logic              done_o
);
  acq_state_e       st;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       depth_q, src_q;
  logic [CH_W-1:0]  chan_q;
  logic [NCH-1:0]   mask;
  logic             ext_trig_rise, ext_clk_rise, tick, setup_ok;

  assign busy_o   = (st == ST_ARMED) || (st == ST_ACQ);
  assign done_o   = (st == ST_DONE);
  assign chan_o   = chan_q;
  assign setup_ok = setup_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      depth_q <= '0;
      src_q   <= '0;
      chan_q  <= '0;
    end else if (setup_ok) begin
      div_q   <= setup_div_i;
      depth_q <= setup_depth_i;
      src_q   <= setup_src_i;
      chan_q  <= setup_chan_i;
    end
  end

  // R8
  setup_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(div_q) && $stable(depth_q) && $stable(src_q) && $stable(chan_q)));

  acq_sync_edge #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk_i, .rst_ni, .async_i(ext_trig_i), .rise_o(ext_trig_rise)
  );

  acq_sync_edge #(.STAGES(SYNC_STAGES)) u_clk_sync (
    .clk_i, .rst_ni, .async_i(ext_clk_i), .rise_o(ext_clk_rise)
  );

  acq_tick_gen #(.DIV_W(DIV_W), .FIX_DIV(FIX_DIV)) u_tick (
    .clk_i, .rst_ni,
    .run_i(st == ST_ACQ), .src_i(src_q), .div_i(div_q),
    .ext_rise_i(ext_clk_rise), .tick_o(tick)
  );

  acq_chan_dec #(.NCH(NCH), .CH_W(CH_W)) u_dec (
    .chan_i(chan_q), .mask_o(mask)
  );

  acq_ctrl #(.NCH(NCH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni,
    .arm_i, .trig_i(trig_i | ext_trig_rise), .eor_i,
    .tick_i(tick), .depth_i(depth_q), .mask_i(mask),
    .state_o(st), .cnv_o, .addr_o
  );
endmodule

// File: tb/acq_seq_tb_top.sv
module acq_seq_tb_top;
  localparam int unsigned FIX = 125;

  typedef struct {
    logic [14:0] mask;
    logic [16:0] addr;
    int          gap;
    string       tag;
  } item_t;

  logic        clk_i = 0, rst_ni = 0;
  logic        setup_i = 0, arm_i = 0, trig_i = 0, eor_i = 0;
  logic        ext_trig_i = 0, ext_clk_i = 0, ext_run = 0;
  logic [20:0] setup_div_i = '0;
  logic [1:0]  setup_depth_i = '0, setup_src_i = '0;
  logic [3:0]  setup_chan_i = '0;
  logic [14:0] cnv_o;
  logic [16:0] addr_o;
  logic [3:0]  chan_o;
  logic        busy_o, done_o;

  int total = 0, bad = 0, cyc = 0, last_cyc = 0, n_pop = 0;
  item_t exp_q[$];

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;
  always @(negedge clk_i) if (ext_run) ext_clk_i <= ~ext_clk_i;

  acq_seq dut_i (.*);

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected samples as convert pulses appear
  always @(negedge clk_i) begin
    if (rst_ni && cnv_o != '0) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected convert pulse", longint'(cnv_o), 0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(cnv_o == it.mask, {it.tag, " R4 mask"}, longint'(cnv_o), longint'(it.mask));
        chk(addr_o == it.addr, {it.tag, " R5 addr"}, longint'(addr_o), longint'(it.addr));
        if (it.gap != 0)
          chk(cyc - last_cyc == it.gap, {it.tag, " R6 spacing"}, cyc - last_cyc, it.gap);
        n_pop++;
      end
      last_cyc = cyc;
    end
  end

  task automatic pulse(ref logic s);
    @(negedge clk_i) s = 1'b1;
    @(negedge clk_i) s = 1'b0;
  endtask

  task automatic do_setup(input int div, input int depth, input int src, input int chan);
    @(negedge clk_i);
    setup_div_i = 21'(div); setup_depth_i = 2'(depth);
    setup_src_i = 2'(src);  setup_chan_i = 4'(chan);
    setup_i = 1'b1;
    @(negedge clk_i) setup_i = 1'b0;
  endtask

  task automatic push(input int n, input logic [14:0] mask, input int gap, input string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.mask = mask; it.addr = 17'(i); it.gap = (i == 0) ? 0 : gap; it.tag = tag;
      exp_q.push_back(it);
    end
  endtask

  task automatic finish_rec(input int depth, input string tag);
    while (!done_o) @(negedge clk_i);
    @(negedge clk_i);
    chk(exp_q.size() == 0, {tag, " R5 all samples seen"}, exp_q.size(), 0);
    chk(!busy_o && done_o, {tag, " R5 done state"}, {busy_o, done_o}, 1);
    chk(addr_o == 17'(depth - 1), {tag, " R5 last addr"}, addr_o, depth - 1);
    exp_q.delete();
  endtask

  initial begin
    repeat (195000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!busy_o && !done_o, "R1 idle flags", {busy_o, done_o}, 0);
    chk(cnv_o == '0, "R1 cnv", cnv_o, 0);
    chk(addr_o == '0, "R1 addr", addr_o, 0);
    chk(chan_o == '0, "R1 chan", chan_o, 0);

    // R2: triggers while idle
    pulse(trig_i);
    @(negedge clk_i) ext_trig_i = 1;
    repeat (4) @(negedge clk_i);
    ext_trig_i = 0;
    repeat (6) @(negedge clk_i);
    chk(!busy_o && !done_o, "R2 trigger in idle ignored", {busy_o, done_o}, 0);

    // A: sw trigger, div 1, 8K, broadcast
    do_setup(1, 0, 0, 0);
    pulse(arm_i);
    @(negedge clk_i);
    chk(busy_o && !done_o, "R2 armed", {busy_o, done_o}, 2);
    push(8192, 15'h7fff, 2, "A");
    pulse(trig_i);
    repeat (50) @(negedge clk_i);
    do_setup(5, 3, 2, 3);  // R8: ignored mid-record
    @(negedge clk_i);
    chk(chan_o == 4'd0, "R8 chan unchanged", chan_o, 0);
    finish_rec(8192, "A");

    // B: ext trigger, ext clock, 8K, channel 5
    do_setup(0, 0, 1, 5);
    chk(chan_o == 4'd5, "R8 setup accepted in done", chan_o, 5);
    pulse(arm_i);
    ext_run = 1;
    push(8192, 15'h0010, 2, "B R3");
    @(negedge clk_i) ext_trig_i = 1;
    repeat (4) @(negedge clk_i);
    ext_trig_i = 0;
    finish_rec(8192, "B");
    ext_run = 0;

    // C: div 0, 32K, channel 15
    do_setup(0, 1, 0, 15);
    pulse(arm_i);
    push(32768, 15'h4000, 1, "C");
    pulse(trig_i);
    finish_rec(32768, "C");

    // D: div 0, 64K, channel 1
    do_setup(0, 2, 0, 1);
    pulse(arm_i);
    push(65536, 15'h0001, 1, "D");
    pulse(trig_i);
    finish_rec(65536, "D");

    // E: fixed reference source, abort by eor
    do_setup(0, 3, 2, 3);
    pulse(arm_i);
    n_pop = 0;
    push(3, 15'h0004, FIX, "E");
    pulse(trig_i);
    while (n_pop < 3) @(negedge clk_i);
    pulse(eor_i);
    @(negedge clk_i);
    chk(done_o && !busy_o, "R7 eor ends record", {busy_o, done_o}, 1);
    repeat (300) @(negedge clk_i);
    chk(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);

    // F: eor while armed
    pulse(arm_i);
    @(negedge clk_i);
    chk(busy_o, "R2 rearm from done", busy_o, 1);
    pulse(eor_i);
    @(negedge clk_i);
    chk(done_o && !busy_o, "R7 eor while armed", {busy_o, done_o}, 1);
    pulse(trig_i);
    repeat (10) @(negedge clk_i);
    chk(done_o, "R3 trigger in done ignored", done_o, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule